// File: doc/BRIEF.md
# EEPROM Address Counter and Page-Write Checker

This block follows the internal word-address counter of a serial two-wire EEPROM. A transaction classifier sits in front of it and supplies events: strobes that carry the word-address bytes, a strobe for each data byte moved, and markers for the start and end of each operation together with the operation kind. For every data byte, the block returns the memory address that byte belongs to. The counter then advances. The counter keeps its value across operations, so a current-address read simply continues from where the last access stopped.

Write operations are also checked against the page geometry. The page holds 2^PAGE_LOG2 bytes. When a write operation ends, the block reports a one-cycle completion pulse and gives the page index of the first and the last byte written. It raises a warning if more bytes were written than a page holds. It raises a second warning if the first and last bytes sit in different pages.

The page checker is a four-state machine. CHK_IDLE moves to CHK_ARMED on the start of a write operation. CHK_ARMED moves to CHK_FILL on the first data byte. If the operation ends with a byte in that same cycle, CHK_ARMED moves straight to CHK_DONE. If the operation ends with no byte at all, CHK_ARMED falls back to CHK_IDLE. CHK_FILL moves to CHK_DONE when the operation ends. CHK_DONE lasts one cycle. It then goes to CHK_ARMED if a new write starts in that cycle, and to CHK_IDLE otherwise.

Top module: `eeprom_addr_tracker`

## Requirements
- R1: After reset, the first data byte that follows no address load is tagged with the parameter INIT_ADDR (its low 8 bits when cfg_wide is 0). tag_valid and pw_done are 0 during reset.
- R2: With cfg_wide = 0 (one address byte):
  - A low-byte load strobe sets the counter to {8'h00, addr_byte}.
  - A high-byte load strobe has no effect.
  - Tag addresses have their upper 8 bits at zero.
  - The counter wraps from 8'hFF to 8'h00.
- R3: With cfg_wide = 1 (two address bytes):
  - A high-byte strobe saves addr_byte.
  - A later low-byte strobe sets the counter to {saved high, addr_byte}.
  - The counter wraps from 16'hFFFF to 16'h0000.
- R4: Each cycle with data_stb = 1 produces tag_valid = 1 in the next cycle, with tag_addr equal to the counter value. The counter then increments by one. Without a load or data strobe, the counter holds its value, including across operations.
- R5: When a write operation (op_kind = 2'b01) that moved at least one data byte ends, pw_done is 1 for exactly the cycle after op_end. In that cycle, pg_first and pg_last hold the first and last tagged addresses shifted right by PAGE_LOG2.
- R6: warn_overrun is 1 together with pw_done when the write moved more than 2^PAGE_LOG2 bytes. Exactly 2^PAGE_LOG2 bytes gives no warning.
- R7: warn_cross is 1 together with pw_done when pg_first differs from pg_last.
- R8: An operation whose op_kind is not 2'b01 produces no pw_done. A write operation that ends without any data byte also produces no pw_done.
- R9: A warning is never raised outside a pw_done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 0: one address byte, 1: two address bytes |
| addr_hi_ld | input | 1 | addr_byte is the high word-address byte |
| addr_lo_ld | input | 1 | addr_byte is the low (or only) word-address byte |
| addr_byte | input | 8 | Word-address byte value |
| data_stb | input | 1 | One data byte transferred |
| op_start | input | 1 | Operation begins |
| op_kind | input | 2 | Operation kind, 2'b01 = write |
| op_end | input | 1 | Operation ends |
| tag_valid | output | 1 | tag_addr is valid this cycle |
| tag_addr | output | 16 | Memory address of the last data byte |
| pw_done | output | 1 | Write operation completed (one cycle) |
| warn_overrun | output | 1 | Write moved more bytes than a page holds |
| warn_cross | output | 1 | Write ran across a page boundary |
| pg_first | output | 16-PAGE_LOG2 | Page index of the first written byte |
| pg_last | output | 16-PAGE_LOG2 | Page index of the last written byte |

## Verification
Both result paths have a latency of one cycle.
- A data strobe sampled at one rising edge shows up as tag_valid and tag_addr right after that edge.
- An op_end sampled at an edge puts the checker in CHK_DONE after that edge. pw_done, both warnings and the page indices then hold for that one cycle only.

The bench drives every stimulus on a falling edge and holds it for one cycle. It samples the results on the falling edge after the following rising edge. The completion checks also look one falling edge later, to confirm that the pulse has ended.

// File: rtl/eat_pkg.sv
package eat_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        OPK_READ_CUR = 2'd0,
        OPK_WRITE    = 2'd1,
        OPK_READ_RND = 2'd2,
        OPK_SPARE    = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        CHK_IDLE  = 2'd0,
        CHK_ARMED = 2'd1,
        CHK_FILL  = 2'd2,
        CHK_DONE  = 2'd3
    } chk_state_e;
endpackage

// File: rtl/eat_counter.sv
module eat_counter
    import eat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] INIT_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              hi_ld,
    input  logic              lo_ld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              step,
    output logic              tag_valid,
    output logic [ADDR_W-1:0] tag_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] cnt_q;
    logic [BYTE_W-1:0] hi_q;
    logic [ADDR_W-1:0] inc_val;
    logic [ADDR_W-1:0] load_val;
    logic [BYTE_W-1:0] low_plus;

    always_comb begin
        cur_addr = cfg_wide ? cnt_q : {{HI_W{1'b0}}, cnt_q[BYTE_W-1:0]};
        low_plus = cnt_q[BYTE_W-1:0] + 1'b1;
        inc_val  = cfg_wide ? cnt_q + 1'b1 : {{HI_W{1'b0}}, low_plus};
        load_val = cfg_wide ? {hi_q, byte_in} : {{HI_W{1'b0}}, byte_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= INIT_ADDR;
            hi_q      <= '0;
            tag_valid <= 1'b0;
            tag_addr  <= '0;
        end else begin
            tag_valid <= step;
            if (step) begin
                tag_addr <= cur_addr;
            end
            if (hi_ld && cfg_wide) begin
                hi_q <= byte_in;
            end
            if (lo_ld) begin
                cnt_q <= load_val;
            end else if (step) begin
                cnt_q <= inc_val;
            end
        end
    end
endmodule

// File: rtl/eat_page_check.sv
module eat_page_check
    import eat_pkg::*;
#(
    parameter int PAGE_LOG2 = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_start,
    input  logic [1:0]              op_kind,
    input  logic                    op_end,
    input  logic                    step,
    input  logic [ADDR_W-1:0]       cur_addr,
    output logic                    pw_done,
    output logic                    warn_overrun,
    output logic                    warn_cross,
    output logic [ADDR_W-PAGE_LOG2-1:0] pg_first,
    output logic [ADDR_W-PAGE_LOG2-1:0] pg_last
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int PG_W  = ADDR_W - PAGE_LOG2;
    localparam logic [CNT_W-1:0] PAGE_BYTES = CNT_W'(1) << PAGE_LOG2;
    localparam logic [CNT_W-1:0] CNT_MAX    = '1;

    chk_state_e        state_q, state_d;
    logic [ADDR_W-1:0] first_q;
    logic [ADDR_W-1:0] last_q;
    logic [CNT_W-1:0]  nbytes_q;
    logic              wr_start;

    assign wr_start = op_start && (op_kind == OPK_WRITE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHK_IDLE: begin
                if (wr_start) state_d = CHK_ARMED;
            end
            CHK_ARMED: begin
                if (op_end)    state_d = step ? CHK_DONE : CHK_IDLE;
                else if (step) state_d = CHK_FILL;
            end
            CHK_FILL: begin
                if (op_end) state_d = CHK_DONE;
            end
            CHK_DONE: begin
                state_d = wr_start ? CHK_ARMED : CHK_IDLE;
            end
            default: state_d = CHK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CHK_IDLE;
            first_q  <= '0;
            last_q   <= '0;
            nbytes_q <= '0;
        end else begin
            state_q <= state_d;
            if (step && state_q == CHK_ARMED) begin
                first_q  <= cur_addr;
                last_q   <= cur_addr;
                nbytes_q <= CNT_W'(1);
            end else if (step && state_q == CHK_FILL) begin
                last_q <= cur_addr;
                if (nbytes_q != CNT_MAX) begin
                    nbytes_q <= nbytes_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        pw_done      = 1'b0;
        warn_overrun = 1'b0;
        warn_cross   = 1'b0;
        pg_first     = '0;
        pg_last      = '0;
        if (state_q == CHK_DONE) begin
            pw_done      = 1'b1;
            pg_first     = PG_W'(first_q >> PAGE_LOG2);
            pg_last      = PG_W'(last_q >> PAGE_LOG2);
            warn_overrun = nbytes_q > PAGE_BYTES;
            warn_cross   = (first_q >> PAGE_LOG2) != (last_q >> PAGE_LOG2);
        end
    end
endmodule

// File: rtl/eeprom_addr_tracker.sv
module eeprom_addr_tracker
    import eat_pkg::*;
#(
    parameter logic [15:0] INIT_ADDR = 16'h0000,
    parameter int          PAGE_LOG2 = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wide,
    input  logic                    addr_hi_ld,
    input  logic                    addr_lo_ld,
    input  logic [7:0]              addr_byte,
    input  logic                    data_stb,
    input  logic                    op_start,
    input  logic [1:0]              op_kind,
    input  logic                    op_end,
    output logic                    tag_valid,
    output logic [15:0]             tag_addr,
    output logic                    pw_done,
    output logic                    warn_overrun,
    output logic                    warn_cross,
    output logic [16-PAGE_LOG2-1:0] pg_first,
    output logic [16-PAGE_LOG2-1:0] pg_last
);
    logic [ADDR_W-1:0] cur_addr;

    eat_counter #(.INIT_ADDR(INIT_ADDR)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wide  (cfg_wide),
        .hi_ld     (addr_hi_ld),
        .lo_ld     (addr_lo_ld),
        .byte_in   (addr_byte),
        .step      (data_stb),
        .tag_valid (tag_valid),
        .tag_addr  (tag_addr),
        .cur_addr  (cur_addr)
    );

    eat_page_check #(.PAGE_LOG2(PAGE_LOG2)) u_chk_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_start     (op_start),
        .op_kind      (op_kind),
        .op_end       (op_end),
        .step         (data_stb),
        .cur_addr     (cur_addr),
        .pw_done      (pw_done),
        .warn_overrun (warn_overrun),
        .warn_cross   (warn_cross),
        .pg_first     (pg_first),
        .pg_last      (pg_last)
    );
endmodule

// File: rtl/eat_checker.sv
module eat_checker #(
    parameter int PAGE_LOG2 = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_wide,
    input logic                    addr_hi_ld,
    input logic                    addr_lo_ld,
    input logic [7:0]              addr_byte,
    input logic                    data_stb,
    input logic                    op_start,
    input logic [1:0]              op_kind,
    input logic                    op_end,
    input logic                    tag_valid,
    input logic [15:0]             tag_addr,
    input logic                    pw_done,
    input logic                    warn_overrun,
    input logic                    warn_cross,
    input logic [16-PAGE_LOG2-1:0] pg_first,
    input logic [16-PAGE_LOG2-1:0] pg_last
);
    // R4
    tag_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |=> tag_valid);

    // R4
    no_spurious_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_stb |=> !tag_valid);

    // R3
    wide_increment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && $past(data_stb) && !$past(addr_lo_ld) && cfg_wide && $past(cfg_wide))
        |=> (tag_addr == $past(tag_addr) + 16'd1));

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && !$past(cfg_wide)) |-> (tag_addr[15:8] == 8'h00));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_done |=> !pw_done);

    // R9
    warn_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_overrun || warn_cross) |-> pw_done);
endmodule

bind eeprom_addr_tracker eat_checker #(.PAGE_LOG2(PAGE_LOG2)) u_eat_checker (.*);

// File: tb/eeprom_addr_tracker_bench.sv
module eeprom_addr_tracker_bench;
    localparam int CLK_P = 10;
    localparam int PL2   = 3;
    localparam int PGW   = 16 - PL2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wide = 1'b0;
    logic            addr_hi_ld = 1'b0;
    logic            addr_lo_ld = 1'b0;
    logic [7:0]      addr_byte = 8'h00;
    logic            data_stb = 1'b0;
    logic            op_start = 1'b0;
    logic [1:0]      op_kind = 2'b00;
    logic            op_end = 1'b0;
    logic            tag_valid;
    logic [15:0]     tag_addr;
    logic            pw_done;
    logic            warn_overrun;
    logic            warn_cross;
    logic [PGW-1:0]  pg_first;
    logic [PGW-1:0]  pg_last;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    eeprom_addr_tracker #(.INIT_ADDR(16'h00A5), .PAGE_LOG2(PL2)) u_eeprom_addr_tracker (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
        .addr_hi_ld(addr_hi_ld), .addr_lo_ld(addr_lo_ld), .addr_byte(addr_byte),
        .data_stb(data_stb), .op_start(op_start), .op_kind(op_kind), .op_end(op_end),
        .tag_valid(tag_valid), .tag_addr(tag_addr), .pw_done(pw_done),
        .warn_overrun(warn_overrun), .warn_cross(warn_cross),
        .pg_first(pg_first), .pg_last(pg_last)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_lo(input logic [7:0] b);
        @(negedge clk);
        addr_lo_ld = 1'b1; addr_byte = b;
        @(negedge clk);
        addr_lo_ld = 1'b0;
    endtask

    task automatic load_hi(input logic [7:0] b);
        @(negedge clk);
        addr_hi_ld = 1'b1; addr_byte = b;
        @(negedge clk);
        addr_hi_ld = 1'b0;
    endtask

    task automatic byte_check(input string req, input logic [15:0] exp);
        @(negedge clk);
        data_stb = 1'b1;
        @(negedge clk);
        data_stb = 1'b0;
        check({req, " tag_valid"}, {31'd0, tag_valid}, 32'd1);
        check({req, " tag_addr"}, {16'd0, tag_addr}, {16'd0, exp});
    endtask

    task automatic op_begin(input logic [1:0] kind);
        @(negedge clk);
        op_start = 1'b1; op_kind = kind;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic op_finish(input string req, input bit done, input bit ovr,
                             input bit crs, input int fp, input int lp);
        @(negedge clk);
        op_end = 1'b1;
        @(negedge clk);
        op_end = 1'b0;
        check({req, " pw_done"}, {31'd0, pw_done}, {31'd0, done});
        check({req, " warn_overrun"}, {31'd0, warn_overrun}, {31'd0, ovr});
        check({req, " warn_cross"}, {31'd0, warn_cross}, {31'd0, crs});
        if (done) begin
            check({req, " pg_first"}, {19'd0, pg_first}, fp);
            check({req, " pg_last"}, {19'd0, pg_last}, lp);
        end
        @(negedge clk);
        check({req, " pulse ends"}, {31'd0, pw_done}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 reset tag_valid", {31'd0, tag_valid}, 32'd0);
        check("R1 reset pw_done", {31'd0, pw_done}, 32'd0);
        byte_check("R1 first byte", 16'h00A5);
        byte_check("R4 increment", 16'h00A6);
    endtask

    task automatic t_narrow;
        cfg_wide = 1'b0;
        load_lo(8'hFE);
        byte_check("R2 load", 16'h00FE);
        byte_check("R2 step", 16'h00FF);
        byte_check("R2 wrap", 16'h0000);
        load_hi(8'h12);
        byte_check("R2 high ignored", 16'h0001);
    endtask

    task automatic t_wide;
        @(negedge clk);
        cfg_wide = 1'b1;
        load_hi(8'h12);
        load_lo(8'h34);
        byte_check("R3 load", 16'h1234);
        byte_check("R3 step", 16'h1235);
        load_hi(8'hFF);
        load_lo(8'hFF);
        byte_check("R3 top", 16'hFFFF);
        byte_check("R3 wrap", 16'h0000);
    endtask

    task automatic t_hold_read;
        repeat (5) @(negedge clk);
        check("R4 idle no tag", {31'd0, tag_valid}, 32'd0);
        op_begin(2'b10);
        byte_check("R4 holds across ops", 16'h0001);
        op_finish("R8 read op", 1'b0, 1'b0, 1'b0, 0, 0);
    endtask

    task automatic t_write_in_page;
        op_begin(2'b01);
        load_hi(8'h00);
        load_lo(8'h10);
        for (int i = 0; i < 4; i++) byte_check("R5 write byte", 16'h0010 + 16'(i));
        op_finish("R5 in-page", 1'b1, 1'b0, 1'b0, 2, 2);
    endtask

    task automatic t_cross;
        op_begin(2'b01);
        load_hi(8'h00);
        load_lo(8'h0E);
        for (int i = 0; i < 3; i++) byte_check("R7 write byte", 16'h000E + 16'(i));
        op_finish("R7 cross", 1'b1, 1'b0, 1'b1, 1, 2);
    endtask

    task automatic t_overrun;
        op_begin(2'b01);
        load_hi(8'h00);
        load_lo(8'h20);
        for (int i = 0; i < 9; i++) byte_check("R6 write byte", 16'h0020 + 16'(i));
        op_finish("R6 overrun", 1'b1, 1'b1, 1'b1, 4, 5);
        op_begin(2'b01);
        load_hi(8'h00);
        load_lo(8'h30);
        for (int i = 0; i < 8; i++) byte_check("R6 full page byte", 16'h0030 + 16'(i));
        op_finish("R6 exact page", 1'b1, 1'b0, 1'b0, 6, 6);
    endtask

    task automatic t_empty_write;
        op_begin(2'b01);
        load_hi(8'h00);
        load_lo(8'h40);
        op_finish("R8 empty write", 1'b0, 1'b0, 1'b0, 0, 0);
        byte_check("R8 counter after empty write", 16'h0040);
    endtask

    task automatic t_narrow_cross;
        @(negedge clk);
        cfg_wide = 1'b0;
        op_begin(2'b01);
        load_lo(8'hFC);
        for (int i = 0; i < 8; i++) byte_check("R7 narrow byte", {8'h00, 8'hFC + 8'(i)});
        op_finish("R7 narrow wrap cross", 1'b1, 1'b0, 1'b1, 16'h1F, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_narrow();
        t_wide();
        t_hold_read();
        t_write_in_page();
        t_cross();
        t_overrun();
        t_empty_write();
        t_narrow_cross();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule